// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps through the 8421 BCD codes 0 to 9 and returns to 0 after 9. A digit can be preset from a 4-bit input on a clock edge, cleared to zero, or held. Two separate count enables control counting. One is a local enable. The other is a chain enable, and it also qualifies the carry output. Several stages can therefore be strung together: each stage's carry feeds the chain enable of the next, and one shared signal drives every local enable. The result is a multi-digit counter in which every digit changes on the same clock edge.

A build-time parameter chooses how the clear behaves. It is either asynchronous, acting at once and without the clock, or synchronous, sampled on the rising edge. Codes 10 to 15 are not valid BCD. If a stage is loaded with one of them, or starts in one, it falls back into the normal sequence after at most two counting edges.

Top module: `bcd_decade_stage`

## Requirements
- R1: Counting from 9 (binary 1001) gives 0 (0000) on the next counting edge.
- R2: With ASYNC_CLEAR=1, a low `clear_n` forces `count` to 0 at once, without waiting for a clock edge. It overrides the load and both enables.
- R3: With ASYNC_CLEAR=0, a low `clear_n` sampled at a rising edge makes `count` 0 after that edge. It takes priority over both loading and counting.
- R4: When the clear is inactive, a low `load_n` at a rising edge copies `load_val` into `count`. The value is stored as given and is not incremented, even when both enables are high.
- R5: When clear and load are both inactive, `count` steps up by one only when `en_local` and `en_chain` are both high. If either enable is low, `count` keeps its value.
- R6: `carry` is high exactly when `en_chain` is high and `count` equals 9. Any other code, including codes 10 to 15, keeps `carry` low.
- R7: `en_local` has no effect on `carry`. With `count` at 9, `en_chain` high and `en_local` low, `carry` is high and `count` holds.
- R8: Codes 10 to 15 advance when counted as 10→11→6, 12→13→4 and 14→15→2. Every illegal code therefore returns to the range 0 to 9 within two counting edges.
- R9: Three stages chained through `carry`→`en_chain`, with all `en_local` inputs tied together, count 000 to 999 and then wrap to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; asynchronous or synchronous, chosen by ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| load_val | input | 4 | Value to load |
| en_local | input | 1 | Local count enable; does not affect `carry` |
| en_chain | input | 1 | Chain count enable; also qualifies `carry` |
| count | output | 4 | Current BCD digit |
| carry | output | 1 | Terminal-count carry, high when the digit is 9 and `en_chain` is high |

## Verification
The bench runs two three-digit chains side by side, one for each clear style, and compares both with a decimal model on every cycle. A full run of 1000 counting edges exercises the single-digit increment, the 9→0 wrap and the carry rippling into the higher digits. Holding with each enable low on its own separates the two enables: the local enable gates counting only, while the chain enable also gates the carry. Loads of codes 10, 12 and 14, plus a 13 in the middle digit, exercise the recovery paths. Asserting clear together with load and both enables shows the async chain dropping to zero in the middle of a cycle while the sync chain waits for the next clock edge.

// File: rtl/bcd_stage_pkg.sv
// Package bcd_stage_pkg
// Shared digit width, last legal code and the per-edge mode type for the
// decade counter stage. Assumes a 4-bit 8421 digit.
package bcd_stage_pkg;
    localparam int DIGIT_W   = 4;
    localparam int LAST_CODE = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_LOAD  = 2'd2,
        MODE_CLEAR = 2'd3
    } mode_e;
endpackage

// File: rtl/bcd_mode_sel.sv
// Module bcd_mode_sel
// Resolves the control inputs into one action for the next rising edge.
// Priority: clear, then load, then count (both enables high), else hold.
// Assumes all controls are stable around the clock edge.
module bcd_mode_sel
    import bcd_stage_pkg::*;
(
    input  logic  clear_n,
    input  logic  load_n,
    input  logic  en_local,
    input  logic  en_chain,
    output mode_e mode
);
    // Priority decode of the control inputs
    always_comb begin
        if (!clear_n)
            mode = MODE_CLEAR;
        else if (!load_n)
            mode = MODE_LOAD;
        else if (en_local && en_chain)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/bcd_next_code.sv
// Module bcd_next_code
// Next-count logic for one BCD digit, written as per-bit toggle terms.
// The legal codes step 0..9 and back to 0. The same terms send the
// illegal codes 10/12/14 to 11/13/15 and then to 6/4/2.
module bcd_next_code
    import bcd_stage_pkg::*;
(
    input  digit_t cur,
    output digit_t nxt
);
    logic t1, t2, t3;

    // Toggle conditions for each bit
    always_comb begin
        t1 = cur[0] & ~cur[3];
        t2 = cur[0] & cur[1];
        t3 = (cur[3] & cur[0]) | (cur[0] & cur[1] & cur[2]);
        nxt = {cur[3] ^ t3, cur[2] ^ t2, cur[1] ^ t1, ~cur[0]};
    end
endmodule

// File: rtl/bcd_digit_reg.sv
// Module bcd_digit_reg
// Digit storage. The edge action comes from the mode decoder.
// ASYNC_CLEAR=1 adds an asynchronous active-low clear; otherwise clearing
// happens only through MODE_CLEAR on the clock edge.
module bcd_digit_reg
    import bcd_stage_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic   clk,
    input  logic   clear_n,
    input  mode_e  mode,
    input  digit_t load_val,
    input  digit_t nxt,
    output digit_t q
);
    digit_t d_in;

    // Data input chosen by the resolved mode
    always_comb begin
        unique case (mode)
            MODE_CLEAR: d_in = '0;
            MODE_LOAD:  d_in = load_val;
            MODE_COUNT: d_in = nxt;
            default:    d_in = q;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async
            // Digit flop with asynchronous clear
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) q <= '0;
                else          q <= d_in;
            end
        end else begin : g_sync
            logic unused_clear;
            assign unused_clear = clear_n;
            // Digit flop; clear arrives through the mode path
            always_ff @(posedge clk) begin
                q <= d_in;
            end
        end
    endgenerate
endmodule

// File: rtl/bcd_decade_stage.sv
// Module bcd_decade_stage
// One cascadable BCD digit: priority control decode, next-count logic,
// the digit register and the carry decode. The carry is combinational and
// meant for the next stage's chain enable, not for use as a clock or reset.
module bcd_decade_stage
    import bcd_stage_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               en_local,
    input  logic               en_chain,
    output logic [DIGIT_W-1:0] count,
    output logic               carry
);
    localparam digit_t LAST = digit_t'(LAST_CODE);

    mode_e  mode;
    digit_t nxt;

    bcd_mode_sel u_mode (
        .clear_n  (clear_n),
        .load_n   (load_n),
        .en_local (en_local),
        .en_chain (en_chain),
        .mode     (mode)
    );

    bcd_next_code u_next (
        .cur (count),
        .nxt (nxt)
    );

    bcd_digit_reg #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_reg (
        .clk      (clk),
        .clear_n  (clear_n),
        .mode     (mode),
        .load_val (load_val),
        .nxt      (nxt),
        .q        (count)
    );

    // Full decode of the last code, gated by the chain enable only
    always_comb begin
        carry = en_chain && (count == LAST);
    end
endmodule

// File: rtl/bcd_decade_stage_chk.sv
// Module bcd_decade_stage_chk
// Property checker for bcd_decade_stage, attached to every instance by bind.
module bcd_decade_stage_chk #(
    parameter bit ASYNC_CLEAR = 1'b0
) (
    input logic       clk,
    input logic       clear_n,
    input logic       load_n,
    input logic [3:0] load_val,
    input logic       en_local,
    input logic       en_chain,
    input logic [3:0] count,
    input logic       carry
);
    logic counting;
    assign counting = clear_n && load_n && en_local && en_chain;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!clear_n)
        (counting && count == 4'd9) |=> (count == 4'd0)); // R1

    generate
        if (ASYNC_CLEAR) begin : g_async_chk
            // Count must already be zero at any edge where clear is low
            always @(posedge clk) begin
                if (clear_n === 1'b0)
                    AST_ASYNC_CLEAR: assert (count == 4'd0); // R2
            end
        end else begin : g_sync_chk
            AST_SYNC_CLEAR: assert property (@(posedge clk)
                !clear_n |=> (count == 4'd0)); // R3
        end
    endgenerate

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (count == $past(load_val))); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_local && en_chain)) |=> $stable(count)); // R5

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!clear_n)
        (counting && count < 4'd9) |=> (count == $past(count) + 4'd1)); // R5

    AST_CARRY_DECODE: assert property (@(posedge clk) disable iff (!clear_n)
        carry |-> (count == 4'd9 && en_chain)); // R6

    AST_CARRY_FREE_OF_LOCAL: assert property (@(posedge clk) disable iff (!clear_n)
        (en_chain && count == 4'd9) |-> carry); // R7

    AST_ILLEGAL_EXIT: assert property (@(posedge clk) disable iff (!clear_n)
        (counting && count > 4'd9) |=> (count <= 4'd9 || count[0])); // R8
endmodule

bind bcd_decade_stage bcd_decade_stage_chk #(.ASYNC_CLEAR(ASYNC_CLEAR)) u_chk (
    .clk      (clk),
    .clear_n  (clear_n),
    .load_n   (load_n),
    .load_val (load_val),
    .en_local (en_local),
    .en_chain (en_chain),
    .count    (count),
    .carry    (carry)
);

// File: tb/sim_bcd_decade_stage.sv
`timescale 1ns/1ps
// Directed bench: two three-digit chains (sync clear, async clear) driven
// by the same inputs and compared against a decimal model.
module sim_bcd_decade_stage;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        clear_n, load_n, en_local, en_chain;
    logic [11:0] din;
    logic [2:0][3:0] sq, aq;
    logic [2:0]      stc, atc;

    int checks = 0;
    int failures = 0;
    int m [3];

    bcd_decade_stage #(.ASYNC_CLEAR(1'b0)) u0 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[3:0]), .en_local(en_local), .en_chain(en_chain), .count(sq[0]), .carry(stc[0]));
    bcd_decade_stage #(.ASYNC_CLEAR(1'b0)) u1 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[7:4]), .en_local(en_local), .en_chain(stc[0]), .count(sq[1]), .carry(stc[1]));
    bcd_decade_stage #(.ASYNC_CLEAR(1'b0)) u2 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[11:8]), .en_local(en_local), .en_chain(stc[1]), .count(sq[2]), .carry(stc[2]));
    bcd_decade_stage #(.ASYNC_CLEAR(1'b1)) a0 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[3:0]), .en_local(en_local), .en_chain(en_chain), .count(aq[0]), .carry(atc[0]));
    bcd_decade_stage #(.ASYNC_CLEAR(1'b1)) a1 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[7:4]), .en_local(en_local), .en_chain(atc[0]), .count(aq[1]), .carry(atc[1]));
    bcd_decade_stage #(.ASYNC_CLEAR(1'b1)) a2 (.clk(clk), .clear_n(clear_n), .load_n(load_n),
        .load_val(din[11:8]), .en_local(en_local), .en_chain(atc[1]), .count(aq[2]), .carry(atc[2]));

    // Next code per R1/R8
    function automatic int nxt_code(int v);
        case (v)
            9:       return 0;
            10:      return 11;
            11:      return 6;
            12:      return 13;
            13:      return 4;
            14:      return 15;
            15:      return 2;
            default: return v + 1;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model update for one rising edge
    task automatic model_edge();
        bit t0, t1;
        int n [3];
        t0 = en_chain && m[0] == 9;
        t1 = t0 && m[1] == 9;
        for (int k = 0; k < 3; k++) n[k] = m[k];
        if (!clear_n) begin
            for (int k = 0; k < 3; k++) n[k] = 0;
        end else if (!load_n) begin
            for (int k = 0; k < 3; k++) n[k] = int'(din[4*k +: 4]);
        end else if (en_local) begin
            if (en_chain) n[0] = nxt_code(m[0]);
            if (t0)       n[1] = nxt_code(m[1]);
            if (t1)       n[2] = nxt_code(m[2]);
        end
        for (int k = 0; k < 3; k++) m[k] = n[k];
    endtask

    task automatic check_all(string req);
        bit t0, t1, t2;
        t0 = en_chain && m[0] == 9;
        t1 = t0 && m[1] == 9;
        t2 = t1 && m[2] == 9;
        for (int k = 0; k < 3; k++) begin
            chk(req, $sformatf("sync digit%0d", k), int'(sq[k]), m[k]);
            chk(req, $sformatf("async digit%0d", k), int'(aq[k]), m[k]);
        end
        chk("R6", "sync carry", int'(stc), int'({t2, t1, t0}));
        chk("R6", "async carry", int'(atc), int'({t2, t1, t0}));
    endtask

    // One clock: edge, model update, check at the following falling edge
    task automatic cyc(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_load(logic [11:0] v);
        load_n = 1'b0;
        din = v;
        cyc("R4");
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        clear_n = 1'b0; load_n = 1'b1; en_local = 1'b0; en_chain = 1'b0; din = '0;
        for (int k = 0; k < 3; k++) m[k] = 0;
        cyc("R3");
        cyc("R2");
        clear_n = 1'b1;
    endtask

    task automatic t_full_count();
        en_local = 1'b1; en_chain = 1'b1;
        for (int i = 0; i < 1000; i++) cyc("R9");
        chk("R1", "chain wrapped to 000", int'({sq[2], sq[1], sq[0]}), 0);
    endtask

    task automatic t_hold();
        do_load(12'h129);
        en_local = 1'b0; en_chain = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R5");
        chk("R7", "carry with en_local low", int'(stc[0]), 1);
        chk("R7", "held digit", int'(sq[0]), 9);
        en_local = 1'b1; en_chain = 1'b0;
        for (int i = 0; i < 3; i++) cyc("R5");
        chk("R6", "carry with en_chain low", int'(atc[0]), 0);
        en_chain = 1'b1;
        cyc("R1");
        chk("R1", "digit0 after 9", int'(sq[0]), 0);
        chk("R9", "digit1 carried", int'(sq[1]), 3);
    endtask

    task automatic t_load();
        en_local = 1'b1; en_chain = 1'b1;
        do_load(12'h987);
        chk("R4", "loaded not incremented", int'({aq[2], aq[1], aq[0]}), 12'h987);
        cyc("R5");
        cyc("R5");
        chk("R5", "counted to 989", int'({sq[2], sq[1], sq[0]}), 12'h989);
    endtask

    task automatic t_illegal();
        en_local = 1'b1; en_chain = 1'b1;
        do_load(12'h00A);
        cyc("R8");
        chk("R8", "10 to 11", int'(sq[0]), 11);
        cyc("R8");
        chk("R8", "11 to 6", int'(aq[0]), 6);
        do_load(12'h00C);
        cyc("R8");
        cyc("R8");
        chk("R8", "12 to 4 in two", int'(sq[0]), 4);
        do_load(12'h00E);
        chk("R6", "no carry on 14", int'(stc[0]), 0);
        cyc("R8");
        chk("R6", "no carry on 15", int'(stc[0]), 0);
        cyc("R8");
        chk("R8", "14 to 2 in two", int'(sq[0]), 2);
        do_load(12'h0D9);
        cyc("R8");
        chk("R8", "middle 13 to 4", int'(sq[1]), 4);
    endtask

    task automatic t_clear_priority();
        en_local = 1'b1; en_chain = 1'b1;
        do_load(12'h555);
        clear_n = 1'b0; load_n = 1'b0; din = 12'h777;
        #1;
        chk("R2", "async cleared without edge", int'({aq[2], aq[1], aq[0]}), 0);
        chk("R3", "sync waits for edge", int'({sq[2], sq[1], sq[0]}), m[2]*256 + m[1]*16 + m[0]);
        cyc("R3");
        chk("R3", "sync cleared over load", int'({sq[2], sq[1], sq[0]}), 0);
        clear_n = 1'b1; load_n = 1'b1;
        cyc("R5");
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_n = 1'b0; load_n = 1'b1; en_local = 1'b0; en_chain = 1'b0; din = '0;
        @(negedge clk);
        t_reset();
        t_full_count();
        t_hold();
        t_load();
        t_illegal();
        t_clear_priority();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule